// File: doc/BRIEF.md
# Horizontal Sync Regenerator

This block takes a raw horizontal sync signal that has already been sampled into the pixel clock domain. It works out which level of that signal is the active one. It then produces a clean sync output whose polarity and pulse width come from configuration inputs. To decide the polarity, the block counts how many cycles the input spends at each level over a full line, measured from one rising edge to the next. The level that lasts for fewer cycles is taken as the active level.

A leading edge is the input's transition into its active level. Each leading edge starts an output pulse a fixed number of pixel clocks later. That delay equals the latency of the pixel data path, so the regenerated sync stays aligned with the data and the output clock. A coast input lets the system ride through vertical blanking, where sync pulses can be missing or distorted. While coast is high, the block ignores input edges and keeps its polarity decision unchanged.

Sync is a level signal with no flow control. Every pin on this block is a plain control or status pin, so there is no valid/ready interface and no back-pressure.

Top module: `hsync_regen`

## Requirements
- R1: After reset, `sync_out` sits at its inactive level, which is the inverse of `out_active_high`, and `pol_valid` is 0.
- R2: The polarity decision is made at the second of two consecutive input rising edges, with coast low throughout the line between them. At that point `pol_valid` becomes 1. `pol_active_low` becomes 1 when the line had strictly fewer low cycles than high cycles, and 0 otherwise.
- R3: When `out_active_high` is 1, the active level of `sync_out` is 1. When it is 0, the active level is 0.
- R4: Suppose the input is first sampled at its active level on clock edge k. Then `sync_out` becomes active right after edge k+7. `LATENCY` sets this delay and defaults to 7.
- R5: An output pulse lasts exactly `width_cfg` pixel clocks when `width_cfg` is 1 or more.
- R6: A `width_cfg` of 0 gives an output pulse of one pixel clock.
- R7: A new leading edge that arrives while a pulse is still running restarts the width count. The output then stays active for a full width measured from the later start.
- R8: A leading edge sampled while coast is 1 starts no pulse. While coast is 1, `pol_valid` and `pol_active_low` do not change.
- R9: Only the transition into the detected active level starts a pulse. For an active-low input, that transition is the falling edge. For an active-high input, it is the rising edge.
- R10: While `pol_valid` is 0, `sync_out` stays inactive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sync_in | input | 1 | Raw horizontal sync of unknown polarity |
| coast | input | 1 | When 1, ignore sync edges and hold the polarity decision |
| out_active_high | input | 1 | Output polarity: 1 means active high, 0 means active low |
| width_cfg | input | WIDTH_W | Output pulse width in pixel clocks (0 is treated as 1) |
| sync_out | output | 1 | Regenerated, pipeline-aligned sync |
| pol_valid | output | 1 | A polarity decision has been made |
| pol_active_low | output | 1 | Detected input polarity (1 means active low) |

## Verification
A wrong polarity decision shows up at `pol_active_low` one cycle after the second rising edge of a line. About seven cycles after that, it also shows at `sync_out`, as pulses that start on the wrong input transition. A fault in the delay chain moves the start of every pulse away from edge k+7. A fault in the width counter makes a pulse end early or late, which is visible within one width of the pulse start. Coast faults appear as a pulse during the coasted line, or as a change in the polarity outputs while coast is held high.

// File: rtl/hsr_pkg.sv
package hsr_pkg;
  typedef enum logic {
    POL_HIGH = 1'b0,
    POL_LOW  = 1'b1
  } pol_e;

  localparam int unsigned DEF_LATENCY = 7;
  localparam int unsigned DEF_CNT_W   = 12;
  localparam int unsigned DEF_WIDTH_W = 8;
endpackage

// File: rtl/hsr_sampler.sv
module hsr_sampler (
  input  logic clk,
  input  logic rst_n,
  input  logic sync_in,
  input  logic coast,
  output logic lvl,
  output logic rise,
  output logic fall,
  output logic coast_q
);
  logic lvl_d;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lvl     <= 1'b0;
      lvl_d   <= 1'b0;
      coast_q <= 1'b0;
    end else begin
      lvl     <= sync_in;
      lvl_d   <= lvl;
      coast_q <= coast;
    end
  end

  assign rise = lvl & ~lvl_d;
  assign fall = ~lvl & lvl_d;
endmodule

// File: rtl/hsr_pol_detect.sv
module hsr_pol_detect
  import hsr_pkg::*;
#(
  parameter int unsigned CNT_W = DEF_CNT_W
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  input  logic rise,
  input  logic coast_q,
  output logic valid,
  output pol_e pol
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] hi_cnt, lo_cnt;
  logic             armed;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi_cnt <= '0;
      lo_cnt <= '0;
      armed  <= 1'b0;
      valid  <= 1'b0;
      pol    <= POL_HIGH;
    end else if (coast_q) begin
      hi_cnt <= '0;
      lo_cnt <= '0;
      armed  <= 1'b0;
    end else if (rise) begin
      if (armed) begin
        valid <= 1'b1;
        pol   <= (lo_cnt < hi_cnt) ? POL_LOW : POL_HIGH;
      end
      armed  <= 1'b1;
      hi_cnt <= {{(CNT_W-1){1'b0}}, 1'b1};
      lo_cnt <= '0;
    end else if (lvl) begin
      if (hi_cnt != CNT_MAX) hi_cnt <= hi_cnt + 1'b1;
    end else begin
      if (lo_cnt != CNT_MAX) lo_cnt <= lo_cnt + 1'b1;
    end
  end

  // R8: the decision is frozen while coast is held
  assert_coast_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    coast_q |=> ($stable(pol) && $stable(valid)));

  // R2: once a decision exists it is never withdrawn outside reset
  assert_valid_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
    valid |=> valid);
endmodule

// File: rtl/hsr_edge_detect.sv
module hsr_edge_detect
  import hsr_pkg::*;
(
  input  logic rise,
  input  logic fall,
  input  logic coast_q,
  input  logic valid,
  input  pol_e pol,
  output logic lead
);
  logic into_active;

  always_comb begin
    into_active = (pol == POL_LOW) ? fall : rise;
    lead        = valid && !coast_q && into_active;
  end
endmodule

// File: rtl/hsr_pulse_gen.sv
module hsr_pulse_gen #(
  parameter int unsigned LATENCY = hsr_pkg::DEF_LATENCY,
  parameter int unsigned WIDTH_W = hsr_pkg::DEF_WIDTH_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               lead,
  input  logic [WIDTH_W-1:0] width_cfg,
  output logic               pulse_on
);
  localparam int unsigned STAGES = LATENCY - 1;

  logic [STAGES-1:0]  dly;
  logic               load;
  logic [WIDTH_W-1:0] cnt;
  logic [WIDTH_W-1:0] width_eff;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (!rst_n) dly <= '0;
        else        dly <= lead;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (!rst_n) dly <= '0;
        else        dly <= {dly[STAGES-2:0], lead};
      end
    end
  endgenerate

  assign load      = dly[STAGES-1];
  assign width_eff = (width_cfg == '0) ? {{(WIDTH_W-1){1'b0}}, 1'b1} : width_cfg;

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= width_eff;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign pulse_on = (cnt != '0);

  // R4: a delayed edge turns the pulse on at the next edge
  assert_load_starts_R4: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> pulse_on);

  // R6: zero width yields a single cycle
  assert_zero_width_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (load && width_cfg == '0) |=> (cnt == {{(WIDTH_W-1){1'b0}}, 1'b1}));

  // R5: without a reload the count only falls
  assert_count_down_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && cnt != '0) |=> (cnt < $past(cnt)));
endmodule

// File: rtl/hsync_regen.sv
module hsync_regen
  import hsr_pkg::*;
#(
  parameter int unsigned LATENCY = DEF_LATENCY,
  parameter int unsigned CNT_W   = DEF_CNT_W,
  parameter int unsigned WIDTH_W = DEF_WIDTH_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sync_in,
  input  logic               coast,
  input  logic               out_active_high,
  input  logic [WIDTH_W-1:0] width_cfg,
  output logic               sync_out,
  output logic               pol_valid,
  output logic               pol_active_low
);
  logic lvl, rise, fall, coast_q, lead, pulse_on;
  pol_e pol;

  hsr_sampler u_smp (
    .clk(clk), .rst_n(rst_n), .sync_in(sync_in), .coast(coast),
    .lvl(lvl), .rise(rise), .fall(fall), .coast_q(coast_q)
  );

  hsr_pol_detect #(.CNT_W(CNT_W)) u_pol (
    .clk(clk), .rst_n(rst_n), .lvl(lvl), .rise(rise), .coast_q(coast_q),
    .valid(pol_valid), .pol(pol)
  );

  hsr_edge_detect u_edge (
    .rise(rise), .fall(fall), .coast_q(coast_q), .valid(pol_valid),
    .pol(pol), .lead(lead)
  );

  hsr_pulse_gen #(.LATENCY(LATENCY), .WIDTH_W(WIDTH_W)) u_pulse (
    .clk(clk), .rst_n(rst_n), .lead(lead), .width_cfg(width_cfg),
    .pulse_on(pulse_on)
  );

  assign pol_active_low = (pol == POL_LOW);
  assign sync_out       = out_active_high ? pulse_on : ~pulse_on;

  // R10: no pulse can appear before a polarity decision exists
  assert_quiet_until_valid_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !pol_valid |-> (sync_out == !out_active_high));

  initial begin
    assert_latency_param_R4: assert (LATENCY >= 2);
  end
endmodule

// File: tb/tb_hsync_regen.sv
module tb_hsync_regen;
  localparam int LAT = 7;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sync_in = 1'b0;
  logic       coast = 1'b0;
  logic       out_active_high = 1'b1;
  logic [7:0] width_cfg = 8'd5;
  logic       sync_out, pol_valid, pol_active_low;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 0;

  // model state
  bit   chk_en = 0;
  logic act_lvl = 1'b1;
  logic prev_in = 1'b0;
  int   q[$];
  int   cur_start = 0;
  bit   have_cur = 0;

  always #5 clk = ~clk;

  hsync_regen dut (
    .clk(clk), .rst_n(rst_n), .sync_in(sync_in), .coast(coast),
    .out_active_high(out_active_high), .width_cfg(width_cfg),
    .sync_out(sync_out), .pol_valid(pol_valid), .pol_active_low(pol_active_low)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s cycle %0d actual %0d expected %0d", req, cyc, act, exp);
    end
  endtask

  // Reference from R3..R9: pulse starts LAT edges after the active sample, lasts max(width,1)
  always @(posedge clk) begin
    #1;
    cyc++;
    if (!chk_en) begin
      q.delete();
      have_cur = 0;
    end else begin
      int weff;
      bit exp_on;
      if (sync_in == act_lvl && prev_in != act_lvl && !coast) q.push_back(cyc + LAT);
      while (q.size() > 0 && q[0] <= cyc) begin
        cur_start = q.pop_front();
        have_cur = 1;
      end
      weff = (width_cfg == 0) ? 1 : int'(width_cfg);
      exp_on = have_cur && (cyc < cur_start + weff);
      check(sync_out == (exp_on ? out_active_high : !out_active_high),
            "R4/R5/R7/R9 waveform", sync_out, exp_on ? out_active_high : !out_active_high);
    end
    prev_in = sync_in;
  end

  task automatic drive(input logic v, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      sync_in = v;
    end
  endtask

  task automatic line(input logic act, input int a, input int idle);
    drive(act, a);
    drive(~act, idle);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(sync_out == 1'b0, "R1 sync_out inactive", sync_out, 0);
    check(pol_valid == 1'b0, "R1 pol_valid", pol_valid, 0);
    rst_n = 1'b1;
    drive(1'b0, 10);
  endtask

  task automatic t_quiet_until_valid();
    bit seen;
    seen = 0;
    for (int l = 0; l < 2; l++) begin
      drive(1'b1, 6);
      for (int i = 0; i < 34; i++) begin
        @(negedge clk);
        sync_in = 1'b0;
        if (sync_out != 1'b0) seen = 1;
      end
    end
    check(!seen, "R10 no pulse before decision", seen, 0);
    check(pol_valid == 1'b1, "R2 valid after two rises", pol_valid, 1);
    check(pol_active_low == 1'b0, "R2 active-high input", pol_active_low, 0);
  endtask

  task automatic t_active_high_run(input logic oh, input logic [7:0] w, input string tag);
    out_active_high = oh;
    width_cfg = w;
    act_lvl = 1'b1;
    line(1'b1, 6, 34);
    chk_en = 1;
    for (int l = 0; l < 3; l++) line(1'b1, 6, 34);
    chk_en = 0;
    check(pol_active_low == 1'b0, tag, pol_active_low, 0);
  endtask

  task automatic t_active_low();
    out_active_high = 1'b1;
    width_cfg = 8'd9;
    drive(1'b1, 60);
    for (int l = 0; l < 3; l++) line(1'b0, 6, 34);
    check(pol_valid == 1'b1, "R2 valid active-low", pol_valid, 1);
    check(pol_active_low == 1'b1, "R2 active-low decided", pol_active_low, 1);
    act_lvl = 1'b0;
    chk_en = 1;
    for (int l = 0; l < 3; l++) line(1'b0, 6, 34);
    chk_en = 0;
  endtask

  task automatic t_restart();
    int run;
    bit cont;
    width_cfg = 8'd20;
    out_active_high = 1'b1;
    drive(1'b0, 60);
    for (int l = 0; l < 3; l++) line(1'b1, 6, 34);
    check(pol_active_low == 1'b0, "R2 back to active-high", pol_active_low, 0);
    act_lvl = 1'b1;
    chk_en = 1;
    line(1'b1, 2, 10);
    run = 0;
    cont = 1;
    for (int l = 0; l < 4; l++) begin
      for (int i = 0; i < 12; i++) begin
        @(negedge clk);
        sync_in = (i < 2);
        if (sync_out != 1'b1) cont = 0;
        run++;
      end
    end
    check(cont, "R7 restart keeps output active", cont, 1);
    drive(1'b0, 40);
    chk_en = 0;
  endtask

  task automatic t_coast();
    logic pv, pl;
    bit seen;
    width_cfg = 8'd4;
    out_active_high = 1'b1;
    act_lvl = 1'b1;
    for (int l = 0; l < 2; l++) line(1'b1, 6, 34);
    chk_en = 1;
    line(1'b1, 6, 34);
    pv = pol_valid;
    pl = pol_active_low;
    @(negedge clk);
    coast = 1'b1;
    seen = 0;
    for (int l = 0; l < 3; l++) begin
      for (int i = 0; i < 40; i++) begin
        @(negedge clk);
        sync_in = (i < 34);
        if (sync_out != 1'b0) seen = 1;
      end
    end
    check(!seen, "R8 no pulse during coast", seen, 0);
    check(pol_valid == pv, "R8 valid held", pol_valid, pv);
    check(pol_active_low == pl, "R8 polarity held", pol_active_low, pl);
    drive(1'b0, 20);
    coast = 1'b0;
    for (int l = 0; l < 3; l++) line(1'b1, 6, 34);
    chk_en = 0;
    check(pol_active_low == 1'b0, "R8 polarity after coast", pol_active_low, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    t_reset();
    t_quiet_until_valid();
    t_active_high_run(1'b1, 8'd5, "R5 width 5 active-high out");
    t_active_high_run(1'b0, 8'd0, "R3 R6 active-low out zero width");
    t_active_high_run(1'b0, 8'd1, "R3 width 1 active-low out");
    t_active_low();
    t_restart();
    t_coast();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule